// File: doc/BRIEF.md
# Aliased Set/Clear Status Register

This block holds one 64-bit status word behind a simple single-cycle register bus. Three consecutive word addresses map to it. The first one reads and writes the word as-is. The second one changes the word in place, and a parameter picks how. The third one sets bits by OR-ing the write data into the current value. Two agents can therefore raise or drop flags without a read-modify-write race.

Only the top sixteen bits hold state. Every other bit reads as zero. The most significant stored bit drives a level interrupt. An access to an address outside the three-word window, or an access that is not a full 8-byte transfer, produces a one-cycle error strobe and has no effect.

Top module: `alias_status_reg`

## Requirements
- R1: Every stored value is masked so that only bits 63..48 can be 1. Bits 47..0 always read as zero.
- R2: `irq` always equals stored bit 63. It is high while that bit is 1 and low while it is 0, and it changes only as the result of a write.
- R3: The word index is `req_addr >> 3`. A legal write at index `BASE_IDX` replaces the stored value with the masked write data.
- R4: A legal write at index `BASE_IDX+2` stores the current value OR the write data, masked.
- R5: With `CLEAR_ALIAS = 0`, a legal write at index `BASE_IDX+1` stores the current value AND the write data, masked.
- R6: With `CLEAR_ALIAS = 1`, a legal write at index `BASE_IDX+1` sets the register to zero whatever the write data is.
- R7: A legal read at `BASE_IDX` returns the stored value on `rsp_rdata` one cycle after the request. A read at `BASE_IDX+1` or `BASE_IDX+2` returns zero with no error.
- R8: A request whose index is outside `BASE_IDX..BASE_IDX+2`, or whose `req_size` is not 8, gives `err_pulse` high for exactly the cycle after the request and zero read data. Such a write leaves the register unchanged.
- R9: After reset the register is zero, `irq` is low, `rsp_rdata` is zero and `err_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits above 2 form the word index |
| req_size | input | 4 | Transfer size in bytes; only 8 is legal |
| req_wdata | input | 64 | Write data, bit 63 is the most significant (big-endian word) |
| rsp_rdata | output | 64 | Registered read data, valid the cycle after a read |
| err_pulse | output | 1 | One-cycle strobe for an illegal request |
| irq | output | 1 | Level interrupt, copy of stored bit 63 |

## Verification
The modify aliases are driven with data that has ones in both the stored and the unstored halves. This separates the masking from the AND and OR arithmetic, and shows whether an alias uses the current value or only the new data. The AND alias is given data that clears bit 63 while other set bits survive, and the OR alias is given data that sets it again. This shows that the interrupt follows the stored bit in both directions. A second instance built with the clearing variant is written with all-ones data at the alias, which shows that the data really is ignored. Reads at the alias addresses, at one word below and one above the window, and with a short size, tell a zero read apart from an error, and confirm that rejected writes leave the word intact.

// File: rtl/asr_pkg.sv
package asr_pkg;

  localparam int unsigned REG_W = 64;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_DIRECT = 2'd1,
    OP_MODIFY = 2'd2,
    OP_SET    = 2'd3
  } op_e;

  // Mask with the top n bits set.
  function automatic logic [REG_W-1:0] impl_mask(input int unsigned n);
    logic [REG_W-1:0] all_ones;
    all_ones = '1;
    return ~(all_ones >> n);
  endfunction

  // Value stored after an update of the given kind.
  function automatic logic [REG_W-1:0] next_word(
    input op_e              op,
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] wd,
    input logic             clear_alias,
    input logic [REG_W-1:0] mask
  );
    logic [REG_W-1:0] raw;
    case (op)
      OP_DIRECT: raw = wd;
      OP_MODIFY: raw = clear_alias ? '0 : (cur & wd);
      OP_SET:    raw = cur | wd;
      default:   raw = cur;
    endcase
    return raw & mask;
  endfunction

endpackage

// File: rtl/asr_decode.sv
module asr_decode
  import asr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BASE_IDX = 32'h4020
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output op_e               wr_op,
  output logic              rd_base,
  output logic              bad_req
);

  localparam int unsigned IDX_W = ADDR_W - 3;
  localparam logic [IDX_W-1:0] IDX_DIRECT = IDX_W'(BASE_IDX);
  localparam logic [IDX_W-1:0] IDX_MODIFY = IDX_W'(BASE_IDX + 1);
  localparam logic [IDX_W-1:0] IDX_SET    = IDX_W'(BASE_IDX + 2);

  logic [IDX_W-1:0] idx;
  logic hit_direct, hit_modify, hit_set, size_ok, legal;

  assign idx        = req_addr[ADDR_W-1:3];
  assign hit_direct = (idx == IDX_DIRECT);
  assign hit_modify = (idx == IDX_MODIFY);
  assign hit_set    = (idx == IDX_SET);
  assign size_ok    = (req_size == 4'd8);
  assign legal      = req_valid && size_ok && (hit_direct || hit_modify || hit_set);
  assign bad_req    = req_valid && !legal;
  assign rd_base    = legal && !req_write && hit_direct;

  always_comb begin
    wr_op = OP_NONE;
    if (legal && req_write) begin
      if (hit_direct)      wr_op = OP_DIRECT;
      else if (hit_modify) wr_op = OP_MODIFY;
      else                 wr_op = OP_SET;
    end
  end

endmodule

// File: rtl/asr_store.sv
module asr_store
  import asr_pkg::*;
#(
  parameter int unsigned IMPL_W      = 16,
  parameter bit          CLEAR_ALIAS = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              wr_op,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q,
  output logic             irq
);

  localparam logic [REG_W-1:0] MASK = impl_mask(IMPL_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= '0;
    else if (wr_op != OP_NONE) q <= next_word(wr_op, q, wdata, CLEAR_ALIAS, MASK);
  end

  assign irq = q[REG_W-1];

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == '0); // R1
  AST_DIRECT_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_op == OP_DIRECT |=> q == ($past(wdata) & MASK)); // R3
  AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_op == OP_SET |=> (q & $past(q)) == $past(q)); // R4
  AST_AND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!CLEAR_ALIAS && wr_op == OP_MODIFY) |=> (q & ~$past(q)) == '0); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (CLEAR_ALIAS && wr_op == OP_MODIFY) |=> q == '0); // R6

endmodule

// File: rtl/alias_status_reg.sv
module alias_status_reg
  import asr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BASE_IDX    = 32'h4020,
  parameter int unsigned IMPL_W      = 16,
  parameter bit          CLEAR_ALIAS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rsp_rdata,
  output logic              err_pulse,
  output logic              irq
);

  op_e              wr_op;
  logic             rd_base;
  logic             bad_req;
  logic [REG_W-1:0] stored;

  asr_decode #(.ADDR_W(ADDR_W), .BASE_IDX(BASE_IDX)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .wr_op     (wr_op),
    .rd_base   (rd_base),
    .bad_req   (bad_req)
  );

  asr_store #(.IMPL_W(IMPL_W), .CLEAR_ALIAS(CLEAR_ALIAS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_op (wr_op),
    .wdata (req_wdata),
    .q     (stored),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      err_pulse <= 1'b0;
    end else begin
      rsp_rdata <= rd_base ? stored : '0;
      err_pulse <= bad_req;
    end
  end

  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> $stable(stored)); // R8
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> rsp_rdata == '0); // R8
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !rd_base && !bad_req) |=> rsp_rdata == '0); // R7
  AST_IRQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq) |-> $past(wr_op != OP_NONE)); // R2

endmodule

// File: tb/alias_status_reg_tb.sv
module alias_status_reg_tb;

  localparam int unsigned BASE_A = 32'h4020;
  localparam int unsigned BASE_B = 32'h6080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sel_b = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_a, rd_b;
  logic err_a, err_b, irq_a, irq_b;
  logic va, vb;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign va = req_valid && !sel_b;
  assign vb = req_valid && sel_b;

  alias_status_reg #(.BASE_IDX(BASE_A), .CLEAR_ALIAS(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rd_a), .err_pulse(err_a), .irq(irq_a));

  alias_status_reg #(.BASE_IDX(BASE_B), .CLEAR_ALIAS(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rd_b), .err_pulse(err_b), .irq(irq_b));

  // {write, offset, size, wdata, expected rdata, expected err, expected irq}
  // offset 0..3 = BASE+offset, offset 4 = BASE-1
  localparam logic [137:0] VEC [0:15] = '{
    {1'b0, 3'd0, 4'd8, 64'h0, 64'h0, 1'b0, 1'b0},                                   // R9 read after reset
    {1'b1, 3'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b1},                 // R3 direct write
    {1'b0, 3'd0, 4'd8, 64'h0, 64'hFFFF_0000_0000_0000, 1'b0, 1'b1},                 // R1 masked
    {1'b1, 3'd1, 4'd8, 64'h00FF_FFFF_0000_FFFF, 64'h0, 1'b0, 1'b0},                 // R5 AND alias
    {1'b0, 3'd0, 4'd8, 64'h0, 64'h00FF_0000_0000_0000, 1'b0, 1'b0},
    {1'b1, 3'd2, 4'd8, 64'h8001_0000_0000_1234, 64'h0, 1'b0, 1'b1},                 // R4 OR alias
    {1'b0, 3'd0, 4'd8, 64'h0, 64'h80FF_0000_0000_0000, 1'b0, 1'b1},
    {1'b0, 3'd1, 4'd8, 64'h0, 64'h0, 1'b0, 1'b1},                                   // R7 alias read
    {1'b0, 3'd2, 4'd8, 64'h0, 64'h0, 1'b0, 1'b1},
    {1'b1, 3'd3, 4'd8, 64'h0, 64'h0, 1'b1, 1'b1},                                   // R8 above window
    {1'b0, 3'd0, 4'd8, 64'h0, 64'h80FF_0000_0000_0000, 1'b0, 1'b1},
    {1'b1, 3'd0, 4'd4, 64'h0, 64'h0, 1'b1, 1'b1},                                   // R8 short size
    {1'b0, 3'd0, 4'd8, 64'h0, 64'h80FF_0000_0000_0000, 1'b0, 1'b1},
    {1'b0, 3'd4, 4'd8, 64'h0, 64'h0, 1'b1, 1'b1},                                   // R8 below window
    {1'b1, 3'd1, 4'd8, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0},                 // R2 irq drops
    {1'b0, 3'd0, 4'd8, 64'h0, 64'h00FF_0000_0000_0000, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit b, input bit wr, input int unsigned off,
                        input logic [3:0] sz, input logic [63:0] wd);
    int unsigned base, idx;
    base = b ? BASE_B : BASE_A;
    idx  = (off == 4) ? base - 1 : base + off;
    @(negedge clk);
    sel_b = b; req_valid = 1'b1; req_write = wr;
    req_addr = 32'(idx << 3); req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rdata", rd_a, 64'h0);
    check("R9 err", {63'h0, err_a}, 64'h0);
    check("R9 irq", {63'h0, irq_a}, 64'h0);
    check("R9 irq b", {63'h0, irq_b}, 64'h0);

    for (int i = 0; i < 16; i++) begin
      logic [137:0] v;
      v = VEC[i];
      access(1'b0, v[137], int'(v[136:134]), v[133:130], v[129:66]);
      check("R7 rdata", rd_a, v[65:2]);
      check("R8 err", {63'h0, err_a}, {63'h0, v[1]});
      check("R2 irq", {63'h0, irq_a}, {63'h0, v[0]});
    end

    // R8 error strobe lasts one cycle
    access(1'b0, 1'b0, 3, 4'd8, 64'h0);
    check("R8 err set", {63'h0, err_a}, 64'h1);
    @(negedge clk);
    check("R8 err one cycle", {63'h0, err_a}, 64'h0);

    // R9 reset while irq is high
    access(1'b0, 1'b1, 2, 4'd8, 64'h8000_0000_0000_0000);
    check("R2 irq set", {63'h0, irq_a}, 64'h1);
    rst_n = 1'b0;
    #1;
    check("R9 irq after reset", {63'h0, irq_a}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b0, 0, 4'd8, 64'h0);
    check("R9 cleared value", rd_a, 64'h0);

    // Clearing variant
    access(1'b1, 1'b1, 0, 4'd8, 64'h8123_4567_89AB_CDEF);
    check("R2 irq b", {63'h0, irq_b}, 64'h1);
    access(1'b1, 1'b0, 0, 4'd8, 64'h0);
    check("R3 b direct", rd_b, 64'h8123_0000_0000_0000);
    access(1'b1, 1'b1, 1, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 irq b cleared", {63'h0, irq_b}, 64'h0);
    access(1'b1, 1'b0, 0, 4'd8, 64'h0);
    check("R6 b cleared", rd_b, 64'h0);
    access(1'b1, 1'b1, 2, 4'd8, 64'h0040_0000_0000_0001);
    access(1'b1, 1'b0, 0, 4'd8, 64'h0);
    check("R4 b set", rd_b, 64'h0040_0000_0000_0000);
    access(1'b1, 1'b0, 1, 4'd8, 64'h0);
    check("R7 b alias read", rd_b, 64'h0);
    check("R7 b alias no err", {63'h0, err_b}, 64'h0);
    check("R1 a untouched", rd_a, 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule